// File: doc/BRIEF.md
# Periodic SMI Timer with Locked Global Enable

This block holds a 16-bit power-management configuration word and turns a once-per-second tick into a periodic system-management-interrupt request. The word is written from a plain write strobe with data and read back continuously. A 2-bit field picks the interval: 64, 32, 16 or 8 seconds. A down-counter that steps on each tick issues a one-cycle request when it runs out. The request is raised only while a separate global SMI enable is set.

The global enable has its own write strobe. A sticky lock bit in the configuration word shields it. Once software sets the lock, later writes to the global enable do nothing. Writing zero to the lock does not clear it either. Only the platform (core) reset clears it.

A sleep-enable bit lets the CPU sleep output follow the system sleep state. The output can rise only in S1, never in S3, S4 or S5. One read-only bit sits in the resume power well. It has its own reset and is untouched by a core reset.

Top module: `pm_smi_ctrl`

## Requirements
- R1: After core and resume reset, the read data is 0x0200, and the global enable, the SMI request and the CPU sleep output are all 0.
- R2: The rate field is bits [1:0] of the word, encoded as 0 = 64, 1 = 32, 2 = 16 and 3 = 8 ticks. With the global enable set, one SMI request appears for every that many ticks of `sec_tick`. It is high in the cycle after the tick that ends the interval, and the counter then reloads from the current rate.
- R3: The SMI request is one cycle long. It is 0 while the global enable is 0, but the interval counter keeps counting.
- R4: A register write that changes the rate field restarts the count at the new interval. That write takes priority over a tick in the same cycle.
- R5: The lock is bit 4 of the word. Writing 1 sets it. Writing 0 while it is set has no effect, and only the core reset clears it.
- R6: While the lock reads 1, a write on the global-enable strobe leaves `gsmi_en` unchanged. While the lock is 0, such a write loads the value.
- R7: The sleep enable is bit 5 of the word. One cycle after the inputs, `cpu_sleep` is 1 exactly when the sleep enable is 1 and `sleep_state` is 1 (S1). It stays 0 for states 0 (S0), 3 (S3), 4 (S4), 5 (S5) and for the unused codes.
- R8: Bits 15:10, 8:6 and 3:2 read 0 and ignore writes. Bit 9 reads 1 and is set by the resume reset alone, so a core reset leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| core_rst_n | input | 1 | Platform/core reset, active low, asynchronous |
| resume_rst_n | input | 1 | Resume-well reset, active low, asynchronous |
| wr_en | input | 1 | Configuration word write strobe |
| wr_data | input | 16 | Configuration word write data |
| rd_data | output | 16 | Current configuration word |
| gsmi_wr | input | 1 | Global SMI enable write strobe |
| gsmi_wdata | input | 1 | Global SMI enable write value |
| gsmi_en | output | 1 | Current global SMI enable |
| sec_tick | input | 1 | One-cycle pulse once per second |
| sleep_state | input | 3 | Sleep state code (0,1,3,4,5) |
| smi_req | output | 1 | One-cycle periodic SMI request |
| cpu_sleep | output | 1 | CPU sleep request, active high |

## Verification
The interval counter is run at every rate with a tick on every other cycle. Pulse counts tell the four encodings apart. A sparser tick pattern shows that the counter counts ticks, not clock cycles. A run with the global enable cleared shows that the counter keeps its phase while requests are masked. A rate change in mid-count separates a restart at the new interval from a carried-over count. The lock sequence, the sleep-state sweep and the all-ones write separate each gate from a plain pass-through.

// File: rtl/pm_smi_pkg.sv
package pm_smi_pkg;
  localparam int REG_W      = 16;
  localparam int RATE_LSB   = 0;
  localparam int LOCK_BIT   = 4;
  localparam int SLPEN_BIT  = 5;
  localparam int RSM_BIT    = 9;

  typedef enum logic [2:0] {
    ST_S0 = 3'd0,
    ST_S1 = 3'd1,
    ST_S3 = 3'd3,
    ST_S4 = 3'd4,
    ST_S5 = 3'd5
  } sleep_state_e;

  // Interval length in ticks for a rate code: longest interval halved per step.
  function automatic int unsigned period_ticks(input logic [1:0] rate,
                                               input int unsigned base);
    return base >> rate;
  endfunction

  // Sleep output may rise only in S1.
  function automatic logic sleep_allowed(input logic en, input logic [2:0] st);
    return en && (st == 3'(ST_S1));
  endfunction
endpackage

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
  import pm_smi_pkg::*;
(
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             resume_rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_rate,
  input  logic             wr_lock,
  input  logic             wr_slp_en,
  input  logic             gsmi_wr,
  input  logic             gsmi_wdata,
  output logic [1:0]       rate_o,
  output logic             lock_o,
  output logic             slp_en_o,
  output logic             gsmi_en_o,
  output logic             rate_chg_o,
  output logic             gsmi_blocked_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [1:0] rate_q;
  logic       lock_q;
  logic       slp_q;
  logic       gsmi_q;
  logic       rsm_q;

  assign rate_chg_o     = wr_en && (wr_rate != rate_q);
  assign gsmi_blocked_o = gsmi_wr && lock_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rate_q <= 2'd0;
      lock_q <= 1'b0;
      slp_q  <= 1'b0;
      gsmi_q <= 1'b0;
    end else begin
      if (wr_en) begin
        rate_q <= wr_rate;
        slp_q  <= wr_slp_en;
        lock_q <= lock_q | wr_lock;
      end
      if (gsmi_wr && !lock_q) begin
        gsmi_q <= gsmi_wdata;
      end
    end
  end

  // Resume-well bit: its own reset, never written.
  always_ff @(posedge clk or negedge resume_rst_n) begin
    if (!resume_rst_n) rsm_q <= 1'b1;
    else               rsm_q <= rsm_q;
  end

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[RATE_LSB+1:RATE_LSB] = rate_q;
    rd_data_o[LOCK_BIT]           = lock_q;
    rd_data_o[SLPEN_BIT]          = slp_q;
    rd_data_o[RSM_BIT]            = rsm_q;
  end

  assign rate_o    = rate_q;
  assign lock_o    = lock_q;
  assign slp_en_o  = slp_q;
  assign gsmi_en_o = gsmi_q;
endmodule

// File: rtl/pm_smi_timer.sv
module pm_smi_timer
  import pm_smi_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [1:0] rate,
  input  logic       reload,
  input  logic [1:0] reload_rate,
  input  logic       gsmi_en,
  output logic       expire_o,
  output logic       smi_req_o
);
  localparam int CNT_W = $clog2(BASE_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             smi_q;

  assign expire_o = sec_tick && (cnt_q == CNT_W'(1)) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(period_ticks(2'd0, BASE_TICKS));
      smi_q <= 1'b0;
    end else begin
      smi_q <= expire_o && gsmi_en;
      if (reload)        cnt_q <= CNT_W'(period_ticks(reload_rate, BASE_TICKS));
      else if (expire_o) cnt_q <= CNT_W'(period_ticks(rate, BASE_TICKS));
      else if (sec_tick) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign smi_req_o = smi_q;
endmodule

// File: rtl/pm_sleep_gate.sv
module pm_sleep_gate
  import pm_smi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_en,
  input  logic [2:0] sleep_state,
  output logic       cpu_sleep_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_sleep_o <= 1'b0;
    else        cpu_sleep_o <= sleep_allowed(slp_en, sleep_state);
  end
endmodule

// File: rtl/pm_smi_ctrl.sv
module pm_smi_ctrl
  import pm_smi_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 64
) (
  input  logic        clk,
  input  logic        core_rst_n,
  input  logic        resume_rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        gsmi_wr,
  input  logic        gsmi_wdata,
  output logic        gsmi_en,
  input  logic        sec_tick,
  input  logic [2:0]  sleep_state,
  output logic        smi_req,
  output logic        cpu_sleep
);
  logic [1:0] rate;
  logic       lock;
  logic       slp_en;
  logic       rate_chg;
  logic       gsmi_blocked;
  logic       expire;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[15:6], wr_data[3:2]};

  pm_cfg_reg u_cfg (
    .clk            (clk),
    .core_rst_n     (core_rst_n),
    .resume_rst_n   (resume_rst_n),
    .wr_en          (wr_en),
    .wr_rate        (wr_data[RATE_LSB+1:RATE_LSB]),
    .wr_lock        (wr_data[LOCK_BIT]),
    .wr_slp_en      (wr_data[SLPEN_BIT]),
    .gsmi_wr        (gsmi_wr),
    .gsmi_wdata     (gsmi_wdata),
    .rate_o         (rate),
    .lock_o         (lock),
    .slp_en_o       (slp_en),
    .gsmi_en_o      (gsmi_en),
    .rate_chg_o     (rate_chg),
    .gsmi_blocked_o (gsmi_blocked),
    .rd_data_o      (rd_data)
  );

  pm_smi_timer #(.BASE_TICKS(BASE_TICKS)) u_tmr (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .sec_tick    (sec_tick),
    .rate        (rate),
    .reload      (rate_chg),
    .reload_rate (wr_data[RATE_LSB+1:RATE_LSB]),
    .gsmi_en     (gsmi_en),
    .expire_o    (expire),
    .smi_req_o   (smi_req)
  );

  pm_sleep_gate u_slp (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .slp_en      (slp_en),
    .sleep_state (sleep_state),
    .cpu_sleep_o (cpu_sleep)
  );
endmodule

// File: rtl/pm_smi_ctrl_chk.sv
module pm_smi_ctrl_chk (
  input logic        clk,
  input logic        core_rst_n,
  input logic        resume_rst_n,
  input logic        gsmi_wr,
  input logic        gsmi_en,
  input logic        lock,
  input logic        gsmi_blocked,
  input logic        expire,
  input logic        smi_req,
  input logic [2:0]  sleep_state,
  input logic        cpu_sleep,
  input logic [15:0] rd_data
);
  p_src_expire_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    smi_req |-> $past(expire));
  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    smi_req |=> !smi_req);
  p_needs_en_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    smi_req |-> $past(gsmi_en));
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    lock |=> lock);
  p_gsmi_frozen_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (lock && gsmi_wr) |=> $stable(gsmi_en));
  p_blocked_flag_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    gsmi_blocked |=> $stable(gsmi_en));
  p_sleep_s1_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    cpu_sleep |-> ($past(sleep_state) == 3'd1));
  p_resv_zero_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_data & 16'hFDCC) == 16'h0000);
  p_rsm_bit_r8: assert property (@(posedge clk) disable iff (!resume_rst_n)
    rd_data[9]);
endmodule

bind pm_smi_ctrl pm_smi_ctrl_chk u_chk (
  .clk          (clk),
  .core_rst_n   (core_rst_n),
  .resume_rst_n (resume_rst_n),
  .gsmi_wr      (gsmi_wr),
  .gsmi_en      (gsmi_en),
  .lock         (lock),
  .gsmi_blocked (gsmi_blocked),
  .expire       (expire),
  .smi_req      (smi_req),
  .sleep_state  (sleep_state),
  .cpu_sleep    (cpu_sleep),
  .rd_data      (rd_data)
);

// File: tb/pm_smi_ctrl_tb.sv
`timescale 1ns/1ps
module pm_smi_ctrl_tb;
  logic        clk = 1'b0;
  logic        core_rst_n = 1'b0;
  logic        resume_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        gsmi_wr = 1'b0;
  logic        gsmi_wdata = 1'b0;
  logic        gsmi_en;
  logic        sec_tick = 1'b0;
  logic [2:0]  sleep_state = 3'd0;
  logic        smi_req;
  logic        cpu_sleep;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pm_smi_ctrl u_dut (
    .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .gsmi_wr(gsmi_wr), .gsmi_wdata(gsmi_wdata), .gsmi_en(gsmi_en),
    .sec_tick(sec_tick), .sleep_state(sleep_state),
    .smi_req(smi_req), .cpu_sleep(cpu_sleep)
  );

  // Behavioural reference model
  int m_rate, m_cnt;
  bit m_lock, m_slp, m_gsmi, m_smi, m_sleep;

  function automatic int ticks_for(input int r);
    case (r)
      0: return 64;
      1: return 32;
      2: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] m_word();
    logic [15:0] w = 16'h0200;
    w[1:0] = m_rate[1:0];
    w[4] = m_lock;
    w[5] = m_slp;
    return w;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!core_rst_n) begin
      m_rate = 0; m_cnt = 64; m_lock = 0; m_slp = 0;
      m_gsmi = 0; m_smi = 0; m_sleep = 0;
    end else begin
      bit reload, fire, old_lock, old_slp;
      reload   = wr_en && (int'(wr_data[1:0]) != m_rate);
      fire     = sec_tick && (m_cnt == 1) && !reload;
      old_lock = m_lock;
      old_slp  = m_slp;
      m_smi    = fire && m_gsmi;
      if (reload)      m_cnt = ticks_for(int'(wr_data[1:0]));
      else if (fire)   m_cnt = ticks_for(m_rate);
      else if (sec_tick) m_cnt = m_cnt - 1;
      if (wr_en) begin
        m_rate = int'(wr_data[1:0]);
        m_slp  = wr_data[5];
        m_lock = m_lock || wr_data[4];
      end
      if (gsmi_wr && !old_lock) m_gsmi = gsmi_wdata;
      m_sleep = old_slp && (sleep_state == 3'd1);
    end
    #1;
    if (resume_rst_n) begin
      chk("R2", "smi_req", smi_req, m_smi);
      chk("R7", "cpu_sleep", cpu_sleep, m_sleep);
      chk("R6", "gsmi_en", gsmi_en, m_gsmi);
      chk("R8", "rd_data", rd_data, m_word());
      if (smi_req) pulses++;
    end
  end

  task automatic wr_reg(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_gsmi(input logic v);
    @(negedge clk); gsmi_wr = 1'b1; gsmi_wdata = v;
    @(negedge clk); gsmi_wr = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic core_reset();
    @(negedge clk); core_rst_n = 1'b0;
    repeat (2) @(negedge clk); core_rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    resume_rst_n = 1'b1; core_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset rd_data", rd_data, 16'h0200);
    chk("R1", "reset gsmi_en", gsmi_en, 0);
    chk("R1", "reset smi_req", smi_req, 0);
    chk("R1", "reset cpu_sleep", cpu_sleep, 0);

    // R6 unlocked write loads; R2 rate 3 = 8 ticks
    wr_gsmi(1'b1);
    chk("R6", "unlocked gsmi write", gsmi_en, 1);
    wr_reg(16'h0003);
    p0 = pulses; ticks(40, 0);
    chk("R2", "rate3 pulses in 40 ticks", pulses - p0, 5);
    wr_reg(16'h0002);
    p0 = pulses; ticks(48, 0);
    chk("R2", "rate2 pulses in 48 ticks", pulses - p0, 3);
    wr_reg(16'h0001);
    p0 = pulses; ticks(64, 0);
    chk("R2", "rate1 pulses in 64 ticks", pulses - p0, 2);
    wr_reg(16'h0000);
    p0 = pulses; ticks(128, 0);
    chk("R2", "rate0 pulses in 128 ticks", pulses - p0, 2);
    // R2 sparse ticks: counts ticks, not cycles
    wr_reg(16'h0003);
    p0 = pulses; ticks(24, 3);
    chk("R2", "rate3 sparse ticks", pulses - p0, 3);

    // R3 masked while global enable is 0, counter keeps phase
    wr_gsmi(1'b0);
    p0 = pulses; ticks(40, 0);
    chk("R3", "no pulses when disabled", pulses - p0, 0);
    wr_gsmi(1'b1);
    p0 = pulses; ticks(8, 0);
    chk("R3", "phase kept while masked", pulses - p0, 1);

    // R4 rate change restarts count
    wr_reg(16'h0002);
    wr_reg(16'h0003);
    ticks(5, 0);
    wr_reg(16'h0002);
    p0 = pulses; ticks(15, 0);
    chk("R4", "no pulse before new interval", pulses - p0, 0);
    ticks(1, 0);
    chk("R4", "pulse at new interval", pulses - p0, 1);

    // R5 lock set and sticky
    wr_reg(16'h0013);
    chk("R5", "lock set", rd_data[4], 1);
    wr_reg(16'h0003);
    chk("R5", "lock write 0 ignored", rd_data[4], 1);
    // R6 global enable frozen
    wr_gsmi(1'b0);
    chk("R6", "locked gsmi write ignored", gsmi_en, 1);
    // R5/R8 core reset clears lock, bit 9 stays
    core_reset();
    chk("R5", "core reset clears lock", rd_data[4], 0);
    chk("R8", "bit9 after core reset", rd_data[9], 1);
    chk("R1", "gsmi cleared by core reset", gsmi_en, 0);

    // R7 sleep gating
    wr_reg(16'h0020);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); sleep_state = 3'(s);
      @(negedge clk);
      chk("R7", $sformatf("sleep en=1 state=%0d", s), cpu_sleep, (s == 1) ? 1 : 0);
    end
    wr_reg(16'h0000);
    @(negedge clk); sleep_state = 3'd1;
    @(negedge clk);
    chk("R7", "sleep en=0 in S1", cpu_sleep, 0);

    // R8 reserved bits
    wr_reg(16'hFFFF);
    chk("R8", "all-ones write readback", rd_data, 16'h0233);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule